// File: doc/BRIEF.md
# Prioritised Interrupt and Vector Unit

This unit gathers every event that can divert the processor from its instruction stream and decides, on each clock, which one the control sequencer should handle next. Seven sources compete: a supply-fault reset level, a latched bus timeout, an active-low halt request, a power-fail edge, two fixed-vector edge lines and one vectored device request. For every source except the vectored one, the unit forms the service vector address itself. For the vectored request it asks the bus controller for an acknowledge read cycle, which is a data-in strobe together with the daisy-chained acknowledge. It then holds the vector word that the device returns.

The sequencer sees a valid flag, a source code and a vector address. When it accepts the service it pulses a take strobe, and that strobe clears the latch behind the source being shown. The stacking of the program counter and status word is left to the sequencer. The electrical bus timing is left to the bus controller. All inputs are taken to be synchronous to `clk`.

Top module: `intr_vector_unit`

## Requirements
- R1: After rst_n is released with all request lines idle (active-low lines high, ac_ok_i high, dc_fail_i, bus_tmo_i and vreq_i low), svc_valid_o, iak_req_o and init_o are 0 and svc_src_o is 0.
- R2: svc_src_o shows the winning source with these codes: 0 none, 1 supply-fault reset, 2 bus timeout, 3 halt, 4 power fail, 5 fixed line A, 6 fixed line B, 7 vectored. Code 1 has the highest priority, the priority falls as the code rises, and svc_valid_o is 1 exactly when the code is not 0.
- R3: A high-to-low transition on fix_a_n_i or fix_b_n_i is latched and requests vector octal 000100 (line A) or octal 000270 (line B). A line that stays low, or that rises, raises no new request.
- R4: Each edge latch and the timeout latch clears only when svc_take_i is high while its own source is shown. Lower-priority pending requests survive the take of a higher one.
- R5: halt_n_i low is a level request that cannot be masked. It uses vector octal 000170 and remains shown while the line stays low, even after a take.
- R6: A falling edge on ac_ok_i latches a power-fail request with vector octal 000024.
- R7: A one-cycle pulse on bus_tmo_i latches a timeout request with vector octal 000004. This request cannot be masked.
- R8: While dc_fail_i is high the unit shows code 1 with vector 000000, init_o follows dc_fail_i one cycle later, and all latches and any vector fetch are cleared.
- R9: While int_en_i is low, codes 4 to 7 are never shown. Their latched requests are kept and appear once int_en_i returns high.
- R10: With int_en_i high, vreq_i high and nothing else shown, iak_req_o rises on the next cycle. It stays high until iak_done_i, and the next cycle shows code 7 with the iak_data_i word as its vector.
- R11: A fetched vector stays held, unchanged, through a preemption by a higher source until it is taken. A bus_tmo_i pulse during the fetch drops iak_req_o on the next cycle.
- R12: No acknowledge cycle starts while int_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_fail_i | input | 1 | Supply-fault reset level, high when asserted |
| ac_ok_i | input | 1 | Mains good; a falling edge requests power-fail service |
| halt_n_i | input | 1 | Halt-mode request, active low |
| fix_a_n_i | input | 1 | Fixed-vector line A, falling-edge active |
| fix_b_n_i | input | 1 | Fixed-vector line B, falling-edge active |
| vreq_i | input | 1 | Vectored device request |
| bus_tmo_i | input | 1 | Bus timeout pulse from the bus controller |
| int_en_i | input | 1 | Global enable for maskable sources |
| svc_take_i | input | 1 | Sequencer accepts the shown service |
| iak_done_i | input | 1 | Acknowledge read cycle finished, data valid |
| iak_data_i | input | VEC_W | Vector word read from the device |
| iak_req_o | output | 1 | Request for a data-in plus acknowledge bus cycle |
| svc_valid_o | output | 1 | A service is shown |
| svc_src_o | output | 3 | Source code of the shown service |
| svc_vec_o | output | VEC_W | Vector address of the shown service |
| init_o | output | 1 | Peripheral initialise output |

## Verification
Several properties are checked by assertions on every cycle. A falling edge always lands in its latch. A halt level always wins over the maskable sources. Maskable codes never appear while the enable is low. init_o tracks the fault level one cycle late. The acknowledge request holds until it is finished, and a held vector never changes.

Other behaviour needs stimulus sequences, and only the bench scenarios show it. These include the full priority order under every mix of pending sources, with and without the enable. They also cover the drain order as each source is taken, a held-low line raising no new request, a fetched vector surviving preemption, and a fetch being abandoned on timeout or supply fault.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_TMO  = 3'd2,
    SRC_HALT = 3'd3,
    SRC_PWR  = 3'd4,
    SRC_FXA  = 3'd5,
    SRC_FXB  = 3'd6,
    SRC_VEC  = 3'd7
  } src_e;

  localparam int NUM_SRC  = 8;
  localparam int NUM_EDGE = 3;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_BUSY = 2'd1,
    FS_HOLD = 2'd2
  } fetch_e;
endpackage

// File: rtl/ivu_fall_latch.sv
module ivu_fall_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, pend_d, fall_w;

  assign fall_w = prev_q & ~line_i;

  always_comb begin
    if (flush_i) pend_d = '0;
    else         pend_d = (pend_q & ~clr_i) | fall_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R3
      edge_caught_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q[g] && !line_i[g] && !flush_i) |=> pend_o[g]);
    end
  endgenerate
endmodule

// File: rtl/ivu_prio_pick.sv
module ivu_prio_pick
  import ivu_pkg::*;
(
  input  logic [NUM_SRC-1:1] req_i,
  output src_e               win_o
);
  always_comb begin
    win_o = SRC_NONE;
    for (int k = NUM_SRC - 1; k >= 1; k--) begin
      if (req_i[k]) win_o = src_e'(3'(k));
    end
  end
endmodule

// File: rtl/ivu_vec_fetch.sv
module ivu_vec_fetch
  import ivu_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic             abort_i,
  input  logic             flush_i,
  input  logic             take_i,
  output logic             idle_o,
  output logic             busy_o,
  output logic             hold_o,
  output logic [VEC_W-1:0] vec_o
);
  fetch_e           st_q, st_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;

  always_comb begin
    st_d   = st_q;
    vec_en = 1'b0;
    vec_d  = data_i;
    if (flush_i) begin
      st_d = FS_IDLE;
    end else begin
      unique case (st_q)
        FS_IDLE: if (start_i) st_d = FS_BUSY;
        FS_BUSY: begin
          if (abort_i) st_d = FS_IDLE;
          else if (done_i) begin
            st_d   = FS_HOLD;
            vec_en = 1'b1;
          end
        end
        FS_HOLD: if (take_i) st_d = FS_IDLE;
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign idle_o = (st_q == FS_IDLE);
  assign busy_o = (st_q == FS_BUSY);
  assign hold_o = (st_q == FS_HOLD);
  assign vec_o  = vec_q;

  // R10
  iak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i && !abort_i && !flush_i) |=> busy_o);

  // R11
  held_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !take_i && !flush_i) |=> (hold_o && $stable(vec_o)));
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import ivu_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] RST_VEC  = 16'o000000,
  parameter logic [VEC_W-1:0] TMO_VEC  = 16'o000004,
  parameter logic [VEC_W-1:0] HALT_VEC = 16'o000170,
  parameter logic [VEC_W-1:0] PWR_VEC  = 16'o000024,
  parameter logic [VEC_W-1:0] FXA_VEC  = 16'o000100,
  parameter logic [VEC_W-1:0] FXB_VEC  = 16'o000270
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dc_fail_i,
  input  logic             ac_ok_i,
  input  logic             halt_n_i,
  input  logic             fix_a_n_i,
  input  logic             fix_b_n_i,
  input  logic             vreq_i,
  input  logic             bus_tmo_i,
  input  logic             int_en_i,
  input  logic             svc_take_i,
  input  logic             iak_done_i,
  input  logic [VEC_W-1:0] iak_data_i,
  output logic             iak_req_o,
  output logic             svc_valid_o,
  output logic [2:0]       svc_src_o,
  output logic [VEC_W-1:0] svc_vec_o,
  output logic             init_o
);
  localparam int E_PWR = 0;
  localparam int E_FXA = 1;
  localparam int E_FXB = 2;

  logic [NUM_EDGE-1:0] edge_pend, edge_clr;
  logic [NUM_SRC-1:1]  req_w;
  logic                tmo_q, tmo_d;
  logic                init_q;
  logic                take_hit, start_w;
  logic                f_idle, f_busy, f_hold;
  logic [VEC_W-1:0]    f_vec;
  src_e                win;

  ivu_fall_latch #(.N(NUM_EDGE)) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  ({fix_b_n_i, fix_a_n_i, ac_ok_i}),
    .clr_i   (edge_clr),
    .flush_i (dc_fail_i),
    .pend_o  (edge_pend)
  );

  always_comb begin
    req_w[SRC_RST]  = dc_fail_i;
    req_w[SRC_TMO]  = tmo_q;
    req_w[SRC_HALT] = ~halt_n_i;
    req_w[SRC_PWR]  = edge_pend[E_PWR] & int_en_i;
    req_w[SRC_FXA]  = edge_pend[E_FXA] & int_en_i;
    req_w[SRC_FXB]  = edge_pend[E_FXB] & int_en_i;
    req_w[SRC_VEC]  = f_hold & int_en_i;
  end

  ivu_prio_pick u_pick (
    .req_i (req_w),
    .win_o (win)
  );

  assign take_hit = svc_take_i & (win != SRC_NONE);

  always_comb begin
    edge_clr        = '0;
    edge_clr[E_PWR] = take_hit & (win == SRC_PWR);
    edge_clr[E_FXA] = take_hit & (win == SRC_FXA);
    edge_clr[E_FXB] = take_hit & (win == SRC_FXB);
  end

  always_comb begin
    if (dc_fail_i)      tmo_d = 1'b0;
    else if (bus_tmo_i) tmo_d = 1'b1;
    else if (take_hit && win == SRC_TMO) tmo_d = 1'b0;
    else                tmo_d = tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      tmo_q  <= tmo_d;
      init_q <= dc_fail_i;
    end
  end

  assign start_w = vreq_i & int_en_i & f_idle & (win == SRC_NONE);

  ivu_vec_fetch #(.VEC_W(VEC_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .done_i  (iak_done_i),
    .data_i  (iak_data_i),
    .abort_i (bus_tmo_i),
    .flush_i (dc_fail_i),
    .take_i  (take_hit && win == SRC_VEC),
    .idle_o  (f_idle),
    .busy_o  (f_busy),
    .hold_o  (f_hold),
    .vec_o   (f_vec)
  );

  always_comb begin
    unique case (win)
      SRC_RST:  svc_vec_o = RST_VEC;
      SRC_TMO:  svc_vec_o = TMO_VEC;
      SRC_HALT: svc_vec_o = HALT_VEC;
      SRC_PWR:  svc_vec_o = PWR_VEC;
      SRC_FXA:  svc_vec_o = FXA_VEC;
      SRC_FXB:  svc_vec_o = FXB_VEC;
      SRC_VEC:  svc_vec_o = f_vec;
      default:  svc_vec_o = '0;
    endcase
  end

  assign svc_src_o   = win;
  assign svc_valid_o = (win != SRC_NONE);
  assign iak_req_o   = f_busy;
  assign init_o      = init_q;

  // R8
  init_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_fail_i |=> init_o);

  // R5
  halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_n_i && !dc_fail_i && !tmo_q) |-> (svc_src_o == SRC_HALT));

  // R9
  mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_i |-> (svc_src_o < SRC_PWR));

  // R12
  no_fetch_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en_i && !iak_req_o) |=> !($rose(iak_req_o)));
endmodule

// File: tb/intr_vector_unit_tb.sv
`timescale 1ns/1ps
module intr_vector_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n, dc_fail, ac_ok, halt_n, fxa_n, fxb_n, vreq, tmo, en, take, done;
  logic [15:0] data;
  logic        iak_req, valid, init;
  logic [2:0]  src;
  logic [15:0] vec;
  int          checks = 0;
  int          errors = 0;
  bit          m_tmo, m_halt, m_pwr, m_fa, m_fb, m_en;

  always #2.5 clk = ~clk;

  intr_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dc_fail_i(dc_fail), .ac_ok_i(ac_ok),
    .halt_n_i(halt_n), .fix_a_n_i(fxa_n), .fix_b_n_i(fxb_n), .vreq_i(vreq),
    .bus_tmo_i(tmo), .int_en_i(en), .svc_take_i(take), .iak_done_i(done),
    .iak_data_i(data), .iak_req_o(iak_req), .svc_valid_o(valid),
    .svc_src_o(src), .svc_vec_o(vec), .init_o(init)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_vec(input int code);
    case (code)
      2: return 4;
      3: return 'o170;
      4: return 'o24;
      5: return 'o100;
      6: return 'o270;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_code();
    if (m_tmo) return 2;
    if (m_halt) return 3;
    if (m_en && m_pwr) return 4;
    if (m_en && m_fa) return 5;
    if (m_en && m_fb) return 6;
    return 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; dc_fail = 0; ac_ok = 1; halt_n = 1; fxa_n = 1; fxb_n = 1;
    vreq = 0; tmo = 0; en = 1; take = 0; done = 0; data = '0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic take_one();
    take = 1'b1;
    step();
    take = 1'b0;
  endtask

  // R2 R4 R5 R9: compare against the model, take, repeat until empty or halt
  task automatic drain();
    for (int i = 0; i < 8; i++) begin
      int c;
      c = exp_code();
      chk("R2 src", int'(src), c);
      chk("R2 valid", int'(valid), int'(c != 0));
      chk("R4 vec", int'(vec), exp_vec(c));
      if (c == 0 || c == 3) break;
      take_one();
      case (c)
        2: m_tmo = 0;
        4: m_pwr = 0;
        5: m_fa = 0;
        6: m_fb = 0;
        default: ;
      endcase
    end
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 valid", int'(valid), 0);
    chk("R1 src", int'(src), 0);
    chk("R1 iak", int'(iak_req), 0);
    chk("R1 init", int'(init), 0);

    // Sweep every mix of timeout, halt, power fail, line A, line B and enable (R3 R6 R7 R9)
    for (int combo = 0; combo < 64; combo++) begin
      do_reset();
      m_tmo = combo[0]; m_halt = combo[1]; m_pwr = combo[2];
      m_fa = combo[3]; m_fb = combo[4]; m_en = combo[5];
      en = m_en;
      halt_n = ~m_halt;
      tmo = m_tmo; ac_ok = ~m_pwr; fxa_n = ~m_fa; fxb_n = ~m_fb;
      step();
      tmo = 0; ac_ok = 1; fxa_n = 1; fxb_n = 1;
      step();
      drain();
      halt_n = 1'b1; m_halt = 0;
      en = 1'b1; m_en = 1;
      step();
      drain();
    end

    // R3: a line held low raises one request only; a rising edge raises none
    do_reset();
    fxb_n = 0; step();
    chk("R3 fxb code", int'(src), 6);
    take_one();
    step(); step();
    chk("R3 held low", int'(valid), 0);
    fxb_n = 1; step();
    chk("R3 rise", int'(valid), 0);

    // R10: vectored fetch
    do_reset();
    vreq = 1; step();
    chk("R10 iak up", int'(iak_req), 1);
    chk("R10 no valid during fetch", int'(valid), 0);
    step();
    chk("R10 iak held", int'(iak_req), 1);
    done = 1; data = 16'o000310; step();
    done = 0; vreq = 0;
    chk("R10 iak down", int'(iak_req), 0);
    chk("R10 code", int'(src), 7);
    chk("R10 vec", int'(vec), 'o310);
    take_one();
    chk("R10 taken", int'(valid), 0);

    // R11: preemption keeps the fetched vector
    vreq = 1; step(); step();
    done = 1; data = 16'o000344; step();
    done = 0; vreq = 0;
    fxa_n = 0; step(); fxa_n = 1;
    chk("R11 preempt code", int'(src), 5);
    chk("R11 preempt vec", int'(vec), 'o100);
    take_one();
    chk("R11 held code", int'(src), 7);
    chk("R11 held vec", int'(vec), 'o344);
    take_one();
    chk("R11 empty", int'(valid), 0);

    // R11: timeout aborts the fetch
    vreq = 1; step();
    chk("R11 fetching", int'(iak_req), 1);
    tmo = 1; step(); tmo = 0; vreq = 0;
    chk("R11 abort iak", int'(iak_req), 0);
    chk("R11 tmo code", int'(src), 2);
    take_one();
    chk("R11 after abort", int'(valid), 0);

    // R12: masked vectored request starts nothing
    en = 0; vreq = 1; step(); step();
    chk("R12 no iak", int'(iak_req), 0);
    chk("R12 no valid", int'(valid), 0);
    en = 1; step();
    chk("R12 iak after enable", int'(iak_req), 1);
    done = 1; data = 16'o000400; step(); done = 0; vreq = 0;
    take_one();

    // R8: supply fault
    fxa_n = 0; step(); fxa_n = 1;
    vreq = 1; tmo = 0;
    dc_fail = 1; step();
    chk("R8 code", int'(src), 1);
    chk("R8 vec", int'(vec), 0);
    chk("R8 init", int'(init), 1);
    chk("R8 no fetch", int'(iak_req), 0);
    vreq = 0; dc_fail = 0; step();
    chk("R8 init drop", int'(init), 0);
    chk("R8 latches cleared", int'(valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule